// File: doc/BRIEF.md
# Three-Wire Serial Memory Access Port

This block is the slave end of a three-wire serial link. A host reaches an internal register file and memory array through an active-low select, a serial clock and one bidirectional data line. All three pins are brought into the system-clock domain through two-flop synchronizers. Serial clock edges are then found by comparing the synchronized level with its value one system clock earlier. The system clock must run fast enough to see every serial clock phase. With a 4 MHz serial clock and a 100 MHz system clock, each phase lasts about 12 system clocks.

Every access starts with two address bytes. The upper byte holds the direction flag. After the lower byte, the block either stores each incoming data byte or drives data bytes back to the host. In both directions the address advances by one after every byte, for as long as select stays low. For reads, the block turns the data line around and fetches the first byte. It then prefetches the following byte while the current one shifts out. Raising select ends the transfer at once, at any point. Toward the memory the block drives a single-cycle write strobe and a single-cycle read strobe. Read data is expected one system clock after the read strobe.

Top module: `sport_mem_slave`

## Requirements
- R1: While reset is applied and after it is released, sdio_oe_o, mem_wr_o and mem_rd_o are low until a transfer calls for them.
- R2: A transfer starts when select falls. Data is sampled on each rising edge of the serial clock, and each byte arrives least-significant bit first. In the first byte, bit 7 is the direction flag (0 = write, 1 = read). The address is formed as follows: bits 13:8 come from bits 6:1 of the first byte, and bits 7:0 come from the second byte. Bit 0 of the first byte has no effect.
- R3: In a write, each completed data byte produces one mem_wr_o pulse. During that pulse, mem_wdata_o holds the byte, with the first received bit as bit 0, and mem_addr_o holds the current address.
- R4: In a write, each later byte of the same transfer goes to the previous address plus one. The address wraps from 0x3FFF to 0x0000.
- R5: In a read, sdio_oe_o is high once the second address byte is complete. Bit 0 of the byte at the start address is on sdio_o within 2 µs of the last address rising edge. Each later bit changes only after a falling serial clock edge and is valid at the next rising edge.
- R6: A read streams bytes from successive addresses (start, start+1, ...), with the same 14-bit wrap, until select rises.
- R7: When select rises, sdio_oe_o is low by the second rising system clock edge after the pin change.
- R8: A data byte cut short by select rising is never written. The next transfer starts again from its first address bit, even if the previous one stopped mid-byte.
- R9: Serial clock and data activity while select is high causes no memory strobe and no output enable.
- R10: mem_wr_o and mem_rd_o are never high in the same cycle, and each mem_wr_o pulse lasts one system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n_i | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host, idle high |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Data line value driven during reads |
| sdio_oe_o | output | 1 | Output enable for the data line pad |
| mem_addr_o | output | AW (14) | Memory address |
| mem_wr_o | output | 1 | Single-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rd_o | output | 1 | Single-cycle read strobe |
| mem_rdata_i | input | 8 | Read data, valid one clock after mem_rd_o |

## Verification
A pin change reaches the synchronized level two system clock edges later. The edge is acted on at the third edge. A stored byte therefore shows its write strobe three edges after the final rising serial clock edge. For a read, the first bit reaches sdio_o five edges after the last address edge, and each falling edge shifts out a new bit three edges later. The host model keeps each serial clock phase at 13 system clocks and samples read bits just before its rising edge, well after those delays. Write strobes and read strobes are collected at falling system clock edges. After select rises, the output enable is checked at the falling edge that follows the second rising edge, which is exactly the bound R7 allows.

// File: rtl/sport_pkg.sv
// Shared types and constants for the three-wire serial memory port.
// Assumes byte-wide serial framing; widths derive from BYTE_W.
package sport_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);

    // Transfer phases of the serial frame.
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR_HI,
        XS_ADDR_LO,
        XS_WRITE,
        XS_READ
    } xfer_state_e;

endpackage

// File: rtl/sport_pin_sync.sv
// Multi-bit level synchronizer for asynchronous host pins.
// Each bit passes through STAGES flops; reset values come from RST_VAL so
// that idle pin levels are seen during and right after reset.
// Assumes each input changes slowly relative to clk (no bus coherency needed).
module sport_pin_sync #(
    parameter int unsigned    W       = 3,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw pin level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[i]}};
                end else begin
                    chain <= {chain[STAGES-2:0], pin_i[i]};
                end
            end

            assign level_o[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sport_addr_ctr.sv
// Transfer address register.
// Loads its upper field from the first address byte and its lower byte from
// the second; the lower load overwrites the overlap bit. Advances by one on
// every memory strobe, wrapping at the top of the AW-bit space.
// Assumes BYTE_W <= AW <= 2*BYTE_W-2 and that loads and increments never
// coincide (they are separated by at least one serial byte).
module sport_addr_ctr
    import sport_pkg::*;
#(
    parameter int unsigned AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi_i,
    input  logic              ld_lo_i,
    input  logic              inc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [AW-1:0]     addr_o
);

    localparam int unsigned    HI_W = AW - BYTE_W + 1;
    localparam logic [AW-1:0]  ONE  = AW'(1);

    logic [AW-1:0] addr_q;

    // Load address fields or step to the next location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_hi_i) begin
            addr_q[AW-1:BYTE_W-1] <= byte_i[HI_W-1:0];
        end else if (ld_lo_i) begin
            addr_q[BYTE_W-1:0] <= byte_i;
        end else if (inc_i) begin
            addr_q <= addr_q + ONE;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/sport_frame_ctrl.sv
// Serial frame controller.
// Tracks the transfer phase, shifts in bits on synchronized serial clock
// rising edges (LSB first), hands address bytes to the address register,
// issues write strobes and signals the start of a read. Also detects
// serial clock falling edges for the read path.
// Assumes synchronized inputs; a high select level aborts everything.
module sport_frame_ctrl
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lvl_i,
    input  logic              sclk_lvl_i,
    input  logic              sdi_i,
    output logic              ld_hi_o,
    output logic              ld_lo_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rd_start_o,
    output logic              rd_active_o,
    output logic              bit_zero_o,
    output logic              sclk_fall_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(BYTE_W - 1);
    localparam logic [BIT_IDX_W-1:0] BIT_ONE  = BIT_IDX_W'(1);

    xfer_state_e          state_q;
    logic [BIT_IDX_W-1:0] bit_idx_q;
    logic [BYTE_W-2:0]    rx_sh_q;
    logic                 rw_q;
    logic                 sclk_q;
    logic                 sclk_rise;
    logic                 in_rx;
    logic                 byte_done;
    logic [BYTE_W-1:0]    rx_next;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= sclk_lvl_i;
        end
    end

    assign sclk_rise   = sclk_lvl_i & ~sclk_q;
    assign sclk_fall_o = ~sclk_lvl_i & sclk_q;

    // Decode byte completion for the receive phases.
    always_comb begin
        rx_next   = {sdi_i, rx_sh_q};
        in_rx     = (state_q == XS_ADDR_HI) || (state_q == XS_ADDR_LO) ||
                    (state_q == XS_WRITE);
        byte_done = sclk_rise & ~sel_lvl_i & in_rx & (bit_idx_q == BIT_LAST);
    end

    assign ld_hi_o     = byte_done & (state_q == XS_ADDR_HI);
    assign ld_lo_o     = byte_done & (state_q == XS_ADDR_LO);
    assign rd_start_o  = ld_lo_o & rw_q;
    assign byte_o      = rx_next;
    assign rd_active_o = (state_q == XS_READ);
    assign bit_zero_o  = (bit_idx_q == '0);

    // Phase sequencing, bit counting, shifting and write strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= XS_IDLE;
            bit_idx_q <= '0;
            rx_sh_q   <= '0;
            rw_q      <= 1'b0;
            wr_stb_o  <= 1'b0;
            wr_data_o <= '0;
        end else if (sel_lvl_i) begin
            state_q   <= XS_IDLE;
            bit_idx_q <= '0;
            wr_stb_o  <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            if (state_q == XS_IDLE) begin
                state_q   <= XS_ADDR_HI;
                bit_idx_q <= '0;
            end else if (sclk_rise) begin
                rx_sh_q   <= rx_next[BYTE_W-1:1];
                bit_idx_q <= bit_idx_q + BIT_ONE;
                if (bit_idx_q == BIT_LAST) begin
                    case (state_q)
                        XS_ADDR_HI: begin
                            rw_q    <= rx_next[BYTE_W-1];
                            state_q <= XS_ADDR_LO;
                        end
                        XS_ADDR_LO: begin
                            state_q <= rw_q ? XS_READ : XS_WRITE;
                        end
                        XS_WRITE: begin
                            wr_stb_o  <= 1'b1;
                            wr_data_o <= rx_next;
                        end
                        default: begin
                            state_q <= state_q;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sport_read_pipe.sv
// Read data pipeline.
// Fetches the first byte at turnaround, prefetches the next byte while the
// current one shifts out, and shifts one bit per serial clock falling edge.
// The falling edge that precedes bit 0 of a later byte swaps in the
// prefetched byte; the very first falling edge of a read leaves bit 0 alone.
// Assumes read data one clock after the strobe and at least a few system
// clocks between serial clock edges.
module sport_read_pipe
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start_i,
    input  logic              rd_active_i,
    input  logic              abort_i,
    input  logic              sclk_fall_i,
    input  logic              bit_zero_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              rd_req_o,
    output logic              sdo_o
);

    logic              rd_pend_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic [BYTE_W-1:0] pf_q;
    logic              tx_empty_q;
    logic              first_q;

    // Fetch, prefetch and shift-out sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req_o   <= 1'b0;
            rd_pend_q  <= 1'b0;
            tx_sh_q    <= '0;
            pf_q       <= '0;
            tx_empty_q <= 1'b1;
            first_q    <= 1'b1;
        end else if (rd_start_i) begin
            rd_req_o   <= 1'b1;
            rd_pend_q  <= 1'b0;
            tx_empty_q <= 1'b1;
            first_q    <= 1'b1;
        end else if (!rd_active_i || abort_i) begin
            rd_req_o   <= 1'b0;
            rd_pend_q  <= 1'b0;
            tx_empty_q <= 1'b1;
            first_q    <= 1'b1;
        end else begin
            rd_pend_q <= rd_req_o;
            rd_req_o  <= 1'b0;
            if (rd_pend_q) begin
                if (tx_empty_q) begin
                    tx_sh_q    <= rdata_i;
                    tx_empty_q <= 1'b0;
                    rd_req_o   <= 1'b1;
                end else begin
                    pf_q <= rdata_i;
                end
            end
            if (sclk_fall_i) begin
                if (!bit_zero_i) begin
                    tx_sh_q <= {1'b0, tx_sh_q[BYTE_W-1:1]};
                end else if (first_q) begin
                    first_q <= 1'b0;
                end else begin
                    tx_sh_q  <= pf_q;
                    rd_req_o <= 1'b1;
                end
            end
        end
    end

    assign sdo_o = tx_sh_q[0];

endmodule

// File: rtl/sport_mem_slave.sv
// Three-wire serial memory access port, top level.
// Synchronizes the host pins, runs the frame controller, keeps the transfer
// address and streams read data. The data line is enabled only while a read
// is active and the synchronized select is low.
// Assumes clk oversamples the serial clock by well over 4x per phase.
module sport_mem_slave
    import sport_pkg::*;
#(
    parameter int unsigned AW          = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic              mem_wr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    output logic              mem_rd_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam int unsigned PIN_W   = 3;
    localparam int unsigned PIN_SEL = 2;
    localparam int unsigned PIN_CLK = 1;
    localparam int unsigned PIN_DAT = 0;

    logic [PIN_W-1:0]  pin_lvl;
    logic              ld_hi;
    logic              ld_lo;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_start;
    logic              rd_active;
    logic              bit_zero;
    logic              sclk_fall;

    sport_pin_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   ({sel_n_i, sclk_i, sdio_i}),
        .level_o (pin_lvl)
    );

    sport_frame_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_lvl_i   (pin_lvl[PIN_SEL]),
        .sclk_lvl_i  (pin_lvl[PIN_CLK]),
        .sdi_i       (pin_lvl[PIN_DAT]),
        .ld_hi_o     (ld_hi),
        .ld_lo_o     (ld_lo),
        .byte_o      (rx_byte),
        .rd_start_o  (rd_start),
        .rd_active_o (rd_active),
        .bit_zero_o  (bit_zero),
        .sclk_fall_o (sclk_fall),
        .wr_stb_o    (mem_wr_o),
        .wr_data_o   (mem_wdata_o)
    );

    sport_addr_ctr #(
        .AW (AW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi_i (ld_hi),
        .ld_lo_i (ld_lo),
        .inc_i   (mem_wr_o | mem_rd_o),
        .byte_i  (rx_byte),
        .addr_o  (mem_addr_o)
    );

    sport_read_pipe u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_start_i  (rd_start),
        .rd_active_i (rd_active),
        .abort_i     (pin_lvl[PIN_SEL]),
        .sclk_fall_i (sclk_fall),
        .bit_zero_i  (bit_zero),
        .rdata_i     (mem_rdata_i),
        .rd_req_o    (mem_rd_o),
        .sdo_o       (sdio_o)
    );

    assign sdio_oe_o = rd_active & ~pin_lvl[PIN_SEL];

endmodule

// File: rtl/sport_mem_slave_chk.sv
// Assertion checker for the serial memory port, attached by bind.
// Observes only top-level ports.
module sport_mem_slave_chk #(
    parameter int unsigned AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_n_i,
    input logic          sdio_oe_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_wr_o,
    input logic          mem_rd_o
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // R1: the first cycle after reset shows no strobe and no drive.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sdio_oe_o && !mem_wr_o && !mem_rd_o));

    // R10: strobes are exclusive.
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_o && mem_rd_o));

    // R10: a write strobe lasts one clock.
    a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !mem_wr_o);

    // R4 and R6: every strobe moves the address on by exactly one.
    a_r4_addr_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o || mem_rd_o) |=> (mem_addr_o == $past(mem_addr_o) + ONE));

    // R7: output enable is released once select has been high two edges.
    a_r7_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2)) |-> !sdio_oe_o);

    // R9: no memory strobe while select has stayed high.
    a_r9_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2) && $past(sel_n_i, 3))
        |-> (!mem_wr_o && !mem_rd_o));

endmodule

bind sport_mem_slave sport_mem_slave_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n_i    (sel_n_i),
    .sdio_oe_o  (sdio_oe_o),
    .mem_addr_o (mem_addr_o),
    .mem_wr_o   (mem_wr_o),
    .mem_rd_o   (mem_rd_o)
);

// File: tb/sport_mem_slave_bench.sv
// Self-checking bench: a host model drives the serial pins, a synchronous
// memory model answers reads, and write strobes are logged at falling clk.
module sport_mem_slave_bench;

    localparam int AW        = 14;
    localparam int PH        = 13;   // serial clock phase in system clocks
    localparam int LOG_D     = 64;
    localparam int WDOG_CYC  = 150000;

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
        logic [2:0]    n;
        logic [7:0]    d0;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 14'h0123, 3'd1, 8'hA5},
        '{1'b0, 14'h01FE, 3'd3, 8'h3C},
        '{1'b1, 14'h01FE, 3'd3, 8'h00},
        '{1'b0, 14'h2A80, 3'd2, 8'h0F},
        '{1'b1, 14'h2A80, 3'd2, 8'h00},
        '{1'b1, 14'h3FFF, 3'd2, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n_i = 1'b1;
    logic          sclk_i = 1'b1;
    logic          sdio_i = 1'b0;
    logic          sdio_o;
    logic          sdio_oe_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_wr_o;
    logic [7:0]    mem_wdata_o;
    logic          mem_rd_o;
    logic [7:0]    mem_rdata_i = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int wr_n = 0;
    int rd_n = 0;
    int both_n = 0;
    int oe_n = 0;
    logic [AW-1:0] wlog_a [LOG_D];
    logic [7:0]    wlog_d [LOG_D];

    always #5 clk = ~clk;

    sport_mem_slave u_sport_mem_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_i     (sel_n_i),
        .sclk_i      (sclk_i),
        .sdio_i      (sdio_i),
        .sdio_o      (sdio_o),
        .sdio_oe_o   (sdio_oe_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rd_o    (mem_rd_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // Expected content of the memory at a given address.
    function automatic logic [7:0] model(input logic [AW-1:0] a);
        return a[7:0] ^ {a[13:8], 2'b01};
    endfunction

    // Synchronous memory model: data one clock after the read strobe.
    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= model(mem_addr_o);
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_wr_o) begin
            wlog_a[wr_n % LOG_D] = mem_addr_o;
            wlog_d[wr_n % LOG_D] = mem_wdata_o;
            wr_n = wr_n + 1;
        end
        if (mem_rd_o) rd_n = rd_n + 1;
        if (mem_wr_o && mem_rd_o) both_n = both_n + 1;
        if (sdio_oe_o) oe_n = oe_n + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_bit(input logic b);
        sdio_i = b;
        sclk_i = 1'b0;
        wait_clk(PH);
        sclk_i = 1'b1;
        wait_clk(PH);
    endtask

    task automatic tx_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) tx_bit(b[i]);
    endtask

    task automatic rx_byte(output logic [7:0] b, output logic oe_ok);
        oe_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk_i = 1'b0;
            wait_clk(PH);
            b[i] = sdio_o;
            if (!sdio_oe_o) oe_ok = 1'b0;
            sclk_i = 1'b1;
            wait_clk(PH);
        end
    endtask

    task automatic sel_open();
        wait_clk(1);
        sel_n_i = 1'b0;
        wait_clk(20);
    endtask

    task automatic sel_close();
        wait_clk(4);
        sel_n_i = 1'b1;
        wait_clk(20);
    endtask

    // Address phase; bit 0 of the first byte set opposite to address bit 7.
    task automatic send_addr(input logic rd, input logic [AW-1:0] a);
        tx_byte({rd, a[13:8], ~a[7]});
        tx_byte(a[7:0]);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input int n, input logic [7:0] d0);
        int base;
        base = wr_n;
        sel_open();
        send_addr(1'b0, a);
        for (int k = 0; k < n; k++) tx_byte(8'(d0 + 8'(k) * 8'h11));
        sel_close();
        chk("R3 write count", wr_n - base, n);
        for (int k = 0; k < n; k++) begin
            chk("R2 R4 write address", 32'(wlog_a[(base + k) % LOG_D]), 32'(AW'(a + AW'(k))));
            chk("R3 write data", 32'(wlog_d[(base + k) % LOG_D]), 32'(8'(d0 + 8'(k) * 8'h11)));
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int n);
        logic [7:0] b;
        logic       oe_ok;
        sel_open();
        send_addr(1'b1, a);
        wait_clk(190);
        for (int k = 0; k < n; k++) begin
            rx_byte(b, oe_ok);
            chk("R2 R5 R6 read byte", 32'(b), 32'(model(AW'(a + AW'(k)))));
            chk("R5 output enable during read", 32'(oe_ok), 32'(1));
        end
        sel_close();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        wait_clk(WDOG_CYC);
        n_chk = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        logic [7:0] b;
        logic oe_ok;

        wait_clk(5);
        chk("R1 oe in reset", 32'(sdio_oe_o), 32'(0));
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 oe after reset", 32'(sdio_oe_o), 32'(0));
        chk("R1 write strobe after reset", 32'(wr_n), 32'(0));
        chk("R1 read strobe after reset", 32'(rd_n), 32'(0));

        // Table-driven transfers.
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd) do_read(VECS[i].addr, int'(VECS[i].n));
            else            do_write(VECS[i].addr, int'(VECS[i].n), VECS[i].d0);
        end

        // R4: write wrap at the top of the address space.
        do_write(14'h3FFF, 2, 8'hC3);

        // R8: abort in the middle of a write data byte stores nothing.
        base = wr_n;
        sel_open();
        send_addr(1'b0, 14'h0555);
        for (int i = 0; i < 4; i++) tx_bit(1'b1);
        sel_close();
        chk("R8 partial byte not stored", 32'(wr_n - base), 32'(0));

        // R8: abort mid-address, then a clean transfer restarts framing.
        sel_open();
        for (int i = 0; i < 5; i++) tx_bit(1'b1);
        sel_close();
        chk("R8 no write after address abort", 32'(wr_n - base), 32'(0));
        do_write(14'h0777, 1, 8'h5A);

        // R7: select rise during a read releases the data line in time.
        sel_open();
        send_addr(1'b1, 14'h1234);
        wait_clk(190);
        for (int i = 0; i < 3; i++) tx_bit(1'b0);
        chk("R5 oe high before abort", 32'(sdio_oe_o), 32'(1));
        sel_n_i = 1'b1;
        wait_clk(2);
        chk("R7 oe low two edges after select rise", 32'(sdio_oe_o), 32'(0));
        wait_clk(20);

        // R9: pin activity while deselected.
        begin
            int w0, r0, o0;
            w0 = wr_n; r0 = rd_n; o0 = oe_n;
            for (int i = 0; i < 24; i++) tx_bit(i[0] ^ i[2]);
            chk("R9 no write while deselected", 32'(wr_n - w0), 32'(0));
            chk("R9 no read while deselected", 32'(rd_n - r0), 32'(0));
            chk("R9 no drive while deselected", 32'(oe_n - o0), 32'(0));
        end

        // R6: stream after deselected noise still reads correctly.
        sel_open();
        send_addr(1'b1, 14'h00FF);
        wait_clk(190);
        rx_byte(b, oe_ok);
        chk("R6 read after noise", 32'(b), 32'(model(14'h00FF)));
        sel_close();

        chk("R10 strobes never together", 32'(both_n), 32'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule